// File: doc/BRIEF.md
# Page-Buffered Memory Access Controller

This block is the storage side of an addressed serial memory slave. A command decoder in front of it turns bus traffic into single-cycle strobes: load address, store data byte, read one byte, stop, and arm the protect fuse. The block keeps the internal address pointer and gathers write data into a small page buffer. It commits that buffer to a behavioural memory array during a timed busy window that begins at the stop strobe. It also serves current-address, random and sequential reads, and it enforces a one-time write-protect fuse.

A random read is a load-address strobe followed by a stop with no data bytes. This moves the pointer without starting a commit. A sequential read is a run of read strobes, and each one steps the pointer. The size select picks a 128-byte or a 256-byte address space. The fuse protects the whole space at the small size and only its lower half at the large size. While the low-voltage inhibit is high at the moment a commit starts, that commit changes nothing.

Top module: `page_mem_ctrl`

## Requirements
- R1: After reset the block is idle: `busy`, `rd_valid` and `mem_we` are all 0, and the address pointer is 0.
- R2: A load-address strobe followed by N data strobes (1 to 16) and a stop commits all N bytes. Slot i is written to the page base plus ((start offset + i) mod 16). The writes come one per cycle, in ascending slot order, during the first 16 cycles of the busy window.
- R3: When more than 16 data bytes arrive, byte k goes to slot k mod 16, so later bytes overwrite earlier ones oldest first. Exactly one write per occupied slot is issued.
- R4: A stop that starts a commit raises `busy` on the next clock edge and holds it for exactly WR_CYCLES cycles.
- R5: While `busy` is 1, every strobe is ignored. A read gives no `rd_valid`, and an address, data, fuse or stop strobe changes no pointer and no pending state.
- R6: A read strobe while idle returns the byte at the pointer on `rd_data`, with `rd_valid` high for one cycle in the cycle after the strobe. The pointer then advances by one, so repeated strobes read consecutive bytes.
- R7: The pointer and the loaded addresses are masked to 7 bits when `size_large`=0 (so 7Fh wraps to 00h) and to 8 bits when `size_large`=1 (so FFh wraps to 00h).
- R8: After a data commit, the pointer equals the page base plus ((start offset + byte count) mod 16), so the next read continues after the last byte written.
- R9: A load-address strobe followed by a stop with no data bytes sets the pointer and starts no busy window.
- R10: A fuse strobe followed by a stop, while the fuse is not yet set, runs a busy window and sets the fuse at its end. Once the fuse is set it stays set, and further fuse commands start no busy window.
- R11: With the fuse set, commits to protected addresses still run the full busy window but issue no array write. At the small size every address is protected; at the large size addresses 00h to 7Fh are protected and 80h to FFh remain writable.
- R12: If `lv_inhibit` is 1 on the stop that starts a commit, that commit issues no array writes and does not set the fuse, but its busy window still runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| size_large | input | 1 | 1: 256-byte space, 0: 128-byte space |
| lv_inhibit | input | 1 | Low-voltage inhibit, sampled when a commit starts |
| cmd_addr | input | 1 | Strobe: load pointer from `cmd_din`, open a write |
| cmd_data | input | 1 | Strobe: store `cmd_din` in the page buffer |
| cmd_rd | input | 1 | Strobe: read one byte at the pointer |
| cmd_stop | input | 1 | Strobe: end of command, may start a commit |
| cmd_fuse | input | 1 | Strobe: arm the protect-fuse command |
| cmd_din | input | DW | Address or data byte for the strobes |
| rd_data | output | DW | Read data |
| rd_valid | output | 1 | `rd_data` valid for this cycle |
| busy | output | 1 | Commit window in progress |
| mem_we | output | 1 | Array write enable |
| mem_waddr | output | AW | Array write address |
| mem_wdata | output | DW | Array write data |

## Verification
Single-byte commits at different offsets show that a byte reaches the right address, and that the pointer lands one past it. A 20-byte burst starting mid-page tells page wraparound apart from spilling into the next page, and overwrite apart from retention. Reads across 7Fh and FFh, at both sizes, separate the two masks. Commits with the inhibit high, with the fuse set, and with both protected and unprotected targets separate a suppressed write from a dropped busy window. A second fuse command shows that the fuse cannot be set twice.

// File: rtl/pmc_pkg.sv
`timescale 1ns/1ps
package pmc_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_STOP,
    OP_ADDR,
    OP_DATA,
    OP_FUSE,
    OP_READ
  } op_e;

  typedef enum logic {
    CM_DATA,
    CM_FUSE
  } cmode_e;

  // Strobe priority: stop, address, data, fuse, read.
  function automatic op_e pick_op(input logic stop, input logic addr,
                                  input logic data, input logic fuse,
                                  input logic rd);
    if (stop)      return OP_STOP;
    else if (addr) return OP_ADDR;
    else if (data) return OP_DATA;
    else if (fuse) return OP_FUSE;
    else if (rd)   return OP_READ;
    else           return OP_NONE;
  endfunction

endpackage

// File: rtl/pmc_page_buf.sv
`timescale 1ns/1ps
module pmc_page_buf #(
  parameter int DW   = 8,
  parameter int PAGE = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    push,
  input  logic [DW-1:0]           din,
  input  logic [$clog2(PAGE)-1:0] rd_slot,
  output logic [DW-1:0]           slot_data,
  output logic                    slot_valid,
  output logic                    any_valid,
  output logic [$clog2(PAGE)-1:0] fill_idx
);
  localparam int PW = $clog2(PAGE);

  logic [DW-1:0]   data_q [PAGE];
  logic [PAGE-1:0] valid_q, valid_d;
  logic [PW-1:0]   idx_q, idx_d;
  logic            ctl_en;

  assign ctl_en = clr | push;

  always_comb begin
    valid_d = valid_q;
    idx_d   = idx_q;
    if (clr) begin
      valid_d = '0;
      idx_d   = '0;
    end else if (push) begin
      valid_d = valid_q | (PAGE'(1) << idx_q);
      idx_d   = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      idx_q   <= '0;
    end else if (ctl_en) begin
      valid_q <= valid_d;
      idx_q   <= idx_d;
    end
  end

  // Data storage: no reset, written only at the fill position.
  always_ff @(posedge clk) begin
    if (push) data_q[idx_q] <= din;
  end

  assign slot_data  = data_q[rd_slot];
  assign slot_valid = valid_q[rd_slot];
  assign any_valid  = |valid_q;
  assign fill_idx   = idx_q;

  // R3
  slot_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> valid_q[$past(idx_q)]);

endmodule

// File: rtl/pmc_commit_seq.sv
`timescale 1ns/1ps
module pmc_commit_seq #(
  parameter int WR_CYCLES = 1000,
  parameter int PAGE      = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  output logic                    busy,
  output logic [$clog2(PAGE)-1:0] slot,
  output logic                    wr_phase,
  output logic                    done
);
  localparam int PW = $clog2(PAGE);
  localparam int CW = $clog2(WR_CYCLES + 1);
  localparam logic [CW-1:0] LAST     = CW'(WR_CYCLES - 1);
  localparam logic [CW-1:0] PAGE_END = CW'(PAGE);

  logic [CW-1:0] timer_q, timer_d;
  logic          busy_q, busy_d;
  logic          seq_en;

  assign seq_en = busy_q | start;

  always_comb begin
    busy_d  = busy_q;
    timer_d = timer_q;
    if (busy_q) begin
      if (timer_q == LAST) begin
        busy_d  = 1'b0;
        timer_d = '0;
      end else begin
        timer_d = timer_q + 1'b1;
      end
    end else if (start) begin
      busy_d  = 1'b1;
      timer_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      timer_q <= '0;
    end else if (seq_en) begin
      busy_q  <= busy_d;
      timer_q <= timer_d;
    end
  end

  assign busy     = busy_q;
  assign slot     = timer_q[PW-1:0];
  assign wr_phase = busy_q && (timer_q < PAGE_END);
  assign done     = busy_q && (timer_q == LAST);

  // R4
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && timer_q == LAST) |=> !busy_q);

  // R4
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && timer_q != LAST) |=> busy_q);

endmodule

// File: rtl/pmc_array.sv
`timescale 1ns/1ps
module pmc_array #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/page_mem_ctrl.sv
`timescale 1ns/1ps
module page_mem_ctrl
  import pmc_pkg::*;
#(
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter int PAGE      = 16,
  parameter int WR_CYCLES = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          size_large,
  input  logic          lv_inhibit,
  input  logic          cmd_addr,
  input  logic          cmd_data,
  input  logic          cmd_rd,
  input  logic          cmd_stop,
  input  logic          cmd_fuse,
  input  logic [DW-1:0] cmd_din,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          busy,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata
);
  localparam int PW = $clog2(PAGE);
  localparam int HW = AW - PW;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  // Command decode
  op_e           op, act;
  logic [AW-1:0] size_mask, addr_in;

  assign op        = pick_op(cmd_stop, cmd_addr, cmd_data, cmd_fuse, cmd_rd);
  assign act       = busy ? OP_NONE : op;
  assign size_mask = size_large ? {AW{1'b1}} : {1'b0, {(AW-1){1'b1}}};
  assign addr_in   = AW'(cmd_din) & size_mask;

  // State
  logic [AW-1:0] ptr_q, ptr_d;
  logic [HW-1:0] hi_q, hi_d;
  logic [PW-1:0] lo_q, lo_d;
  logic          wr_pend_q, wr_pend_d;
  logic          fuse_req_q, fuse_req_d;
  logic          fuse_q, fuse_d;
  logic          lv_q, lv_d;
  cmode_e        mode_q, mode_d;
  logic [DW-1:0] rd_data_q, rd_data_d;
  logic          rd_valid_q, rd_valid_d;

  // Sub-block wiring
  logic          buf_clr, buf_push, slot_valid, any_valid;
  logic [PW-1:0] fill_idx, slot;
  logic [DW-1:0] slot_data, arr_rdata;
  logic          start_data, start_fuse, commit_start;
  logic          wr_phase, seq_done, prot;

  assign buf_clr      = (act == OP_ADDR);
  assign buf_push     = (act == OP_DATA) && wr_pend_q;
  assign start_data   = (act == OP_STOP) && wr_pend_q && any_valid;
  assign start_fuse   = (act == OP_STOP) && fuse_req_q && !fuse_q;
  assign commit_start = start_data | start_fuse;

  pmc_page_buf #(.DW(DW), .PAGE(PAGE)) u_buf (
    .clk        (clk),
    .rst_n      (rst_sn),
    .clr        (buf_clr),
    .push       (buf_push),
    .din        (cmd_din),
    .rd_slot    (slot),
    .slot_data  (slot_data),
    .slot_valid (slot_valid),
    .any_valid  (any_valid),
    .fill_idx   (fill_idx)
  );

  pmc_commit_seq #(.WR_CYCLES(WR_CYCLES), .PAGE(PAGE)) u_seq (
    .clk      (clk),
    .rst_n    (rst_sn),
    .start    (commit_start),
    .busy     (busy),
    .slot     (slot),
    .wr_phase (wr_phase),
    .done     (seq_done)
  );

  pmc_array #(.AW(AW), .DW(DW)) u_arr (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (ptr_q),
    .rdata (arr_rdata)
  );

  // Next state
  always_comb begin
    ptr_d      = ptr_q;
    hi_d       = hi_q;
    lo_d       = lo_q;
    wr_pend_d  = wr_pend_q;
    fuse_req_d = fuse_req_q;
    lv_d       = lv_q;
    mode_d     = mode_q;
    rd_data_d  = rd_data_q;
    rd_valid_d = 1'b0;
    fuse_d     = fuse_q | (seq_done && (mode_q == CM_FUSE) && !lv_q);
    unique case (act)
      OP_STOP: begin
        wr_pend_d  = 1'b0;
        fuse_req_d = 1'b0;
        if (start_data) begin
          ptr_d  = {hi_q, lo_q + fill_idx};
          mode_d = CM_DATA;
          lv_d   = lv_inhibit;
        end else if (start_fuse) begin
          mode_d = CM_FUSE;
          lv_d   = lv_inhibit;
        end
      end
      OP_ADDR: begin
        ptr_d      = addr_in;
        hi_d       = addr_in[AW-1:PW];
        lo_d       = addr_in[PW-1:0];
        wr_pend_d  = 1'b1;
        fuse_req_d = 1'b0;
      end
      OP_FUSE: begin
        fuse_req_d = 1'b1;
        wr_pend_d  = 1'b0;
      end
      OP_READ: begin
        ptr_d      = (ptr_q + 1'b1) & size_mask;
        rd_data_d  = arr_rdata;
        rd_valid_d = 1'b1;
      end
      default: ;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ptr_q      <= '0;
      hi_q       <= '0;
      lo_q       <= '0;
      wr_pend_q  <= 1'b0;
      fuse_req_q <= 1'b0;
      fuse_q     <= 1'b0;
      lv_q       <= 1'b0;
      mode_q     <= CM_DATA;
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      ptr_q      <= ptr_d;
      hi_q       <= hi_d;
      lo_q       <= lo_d;
      wr_pend_q  <= wr_pend_d;
      fuse_req_q <= fuse_req_d;
      fuse_q     <= fuse_d;
      lv_q       <= lv_d;
      mode_q     <= mode_d;
      rd_data_q  <= rd_data_d;
      rd_valid_q <= rd_valid_d;
    end
  end

  // Array write port
  assign mem_waddr = {hi_q, lo_q + slot};
  assign mem_wdata = slot_data;
  assign prot      = fuse_q & (~size_large | ~mem_waddr[AW-1]);
  assign mem_we    = wr_phase & (mode_q == CM_DATA) & slot_valid & ~lv_q & ~prot;

  assign rd_data  = rd_data_q;
  assign rd_valid = rd_valid_q;

  // R11
  prot_write_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_we |-> !(fuse_q && (!size_large || !mem_waddr[AW-1])));

  // R10
  fuse_keep_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    fuse_q |=> fuse_q);

  // R5
  busy_read_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy && cmd_rd) |=> !rd_valid);

  // R12
  lv_write_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (commit_start && lv_inhibit) |=> !mem_we);

endmodule

// File: tb/test_page_mem_ctrl.sv
`timescale 1ns/1ps
module test_page_mem_ctrl;
  localparam int WRC = 24;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       size_large = 1'b1;
  logic       lv = 1'b0;
  logic       c_addr = 1'b0, c_data = 1'b0, c_rd = 1'b0, c_stop = 1'b0, c_fuse = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] rd_data, mem_waddr, mem_wdata;
  logic       rd_valid, busy, mem_we;

  always #4 clk = ~clk;

  page_mem_ctrl #(.AW(8), .DW(8), .PAGE(16), .WR_CYCLES(WRC)) i_page_mem_ctrl (
    .clk(clk), .rst_n(rst_n), .size_large(size_large), .lv_inhibit(lv),
    .cmd_addr(c_addr), .cmd_data(c_data), .cmd_rd(c_rd), .cmd_stop(c_stop),
    .cmd_fuse(c_fuse), .cmd_din(din), .rd_data(rd_data), .rd_valid(rd_valid),
    .busy(busy), .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit model_on = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Behavioural reference model
  int  m_ram [256];
  bit  m_known [256];
  bit  m_busy = 0;
  int  m_tick = 0;
  int  m_ptr = 0;
  int  m_base = 0;
  bit  m_fuse = 0, m_wpend = 0, m_freq = 0, m_mode_fuse = 0, m_lv = 0;
  byte unsigned q [$];
  bit  e_we [16];
  int  e_addr [16];
  int  e_data [16];
  bit  m_rdv = 0;
  int  m_rdd = 0;

  task automatic model_step();
    bit was;
    int mask;
    was  = m_busy;
    mask = size_large ? 255 : 127;
    if (m_busy) begin
      if (m_tick < 16 && e_we[m_tick]) begin
        m_ram[e_addr[m_tick]]   = e_data[m_tick];
        m_known[e_addr[m_tick]] = 1;
      end
      m_tick++;
      if (m_tick == WRC) begin
        m_busy = 0;
        if (m_mode_fuse && !m_lv) m_fuse = 1;
      end
    end
    m_rdv = 0;
    if (!was) begin
      if (c_stop) begin
        if (m_wpend && q.size() > 0) begin
          for (int s = 0; s < 16; s++) e_we[s] = 0;
          for (int k = 0; k < q.size(); k++) begin
            e_we[k % 16]   = 1;
            e_addr[k % 16] = (m_base & ~15) | ((m_base + k) & 15);
            e_data[k % 16] = q[k];
          end
          for (int s = 0; s < 16; s++)
            if (lv || (m_fuse && (!size_large || e_addr[s] < 128))) e_we[s] = 0;
          m_mode_fuse = 0; m_lv = lv; m_busy = 1; m_tick = 0;
          m_ptr = (m_base & ~15) | ((m_base + q.size()) & 15);
        end else if (m_freq && !m_fuse) begin
          for (int s = 0; s < 16; s++) e_we[s] = 0;
          m_mode_fuse = 1; m_lv = lv; m_busy = 1; m_tick = 0;
        end
        m_wpend = 0; m_freq = 0;
      end else if (c_addr) begin
        m_ptr = din & mask; m_base = m_ptr;
        q.delete(); m_wpend = 1; m_freq = 0;
      end else if (c_data) begin
        if (m_wpend) q.push_back(din);
      end else if (c_fuse) begin
        m_freq = 1; m_wpend = 0;
      end else if (c_rd) begin
        m_rdv = 1; m_rdd = m_ram[m_ptr];
        if (!m_known[m_ptr]) m_rdd = -1;
        m_ptr = (m_ptr + 1) & mask;
      end
    end
  endtask

  always @(posedge clk) if (model_on) model_step();

  // Per-clock comparison
  always @(negedge clk) begin
    if (model_on) begin
      bit ewe;
      ewe = m_busy && m_tick < 16 && e_we[m_tick];
      chk(busy == m_busy, "R4 busy", busy, m_busy);
      chk(mem_we == ewe, "R2 mem_we", mem_we, ewe);
      if (mem_we && ewe) begin
        chk(mem_waddr == e_addr[m_tick], "R2 write address", mem_waddr, e_addr[m_tick]);
        chk(mem_wdata == e_data[m_tick], "R3 write data", mem_wdata, e_data[m_tick]);
      end
      chk(rd_valid == m_rdv, "R6 rd_valid", rd_valid, m_rdv);
      if (rd_valid && m_rdv && m_rdd >= 0)
        chk(rd_data == m_rdd, "R6 rd_data", rd_data, m_rdd);
    end
  end

  localparam int K_ADDR = 0, K_DATA = 1, K_RD = 2, K_STOP = 3, K_FUSE = 4;

  task automatic pulse(input int kind, input logic [7:0] d);
    @(negedge clk);
    din = d;
    case (kind)
      K_ADDR:  c_addr = 1'b1;
      K_DATA:  c_data = 1'b1;
      K_RD:    c_rd   = 1'b1;
      K_STOP:  c_stop = 1'b1;
      default: c_fuse = 1'b1;
    endcase
    @(negedge clk);
    {c_addr, c_data, c_rd, c_stop, c_fuse} = '0;
  endtask

  task automatic wait_idle(output int nb, output int nwe);
    nb = 0; nwe = 0;
    while (busy) begin
      nb++;
      if (mem_we) nwe++;
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [7:0] a, input int n, input logic [7:0] first,
                    output int nb, output int nwe);
    pulse(K_ADDR, a);
    for (int k = 0; k < n; k++) pulse(K_DATA, first + 8'(k));
    pulse(K_STOP, 8'h00);
    wait_idle(nb, nwe);
  endtask

  task automatic seek(input logic [7:0] a);
    pulse(K_ADDR, a);
    pulse(K_STOP, 8'h00);
    chk(busy == 1'b0, "R9 address-only stop starts no busy", busy, 0);
  endtask

  task automatic rd_exp(input logic [7:0] exp, input string req);
    pulse(K_RD, 8'h00);
    chk(rd_valid === 1'b1 && rd_data === exp, req, rd_data, exp);
  endtask

  initial begin
    int nb, nwe;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
    chk(rd_valid == 1'b0, "R1 rd_valid after reset", rd_valid, 0);
    chk(mem_we == 1'b0, "R1 mem_we after reset", mem_we, 0);
    model_on = 1;

    // Single-byte commits and current-address read
    wr(8'h26, 1, 8'hB1, nb, nwe);
    chk(nb == WRC, "R4 busy window length", nb, WRC);
    chk(nwe == 1, "R2 one write for one byte", nwe, 1);
    wr(8'h25, 1, 8'hA1, nb, nwe);
    rd_exp(8'hB1, "R8 current read after write");
    chk(m_ptr == 8'h27, "R1 model pointer sanity", m_ptr, 8'h27);

    // Multi-byte page and sequential read
    wr(8'h30, 3, 8'hC0, nb, nwe);
    chk(nwe == 3, "R2 three writes", nwe, 3);
    seek(8'h30);
    rd_exp(8'hC0, "R6 sequential byte 0");
    rd_exp(8'hC1, "R6 sequential byte 1");
    rd_exp(8'hC2, "R6 sequential byte 2");

    // Page overrun
    wr(8'h43, 20, 8'h10, nb, nwe);
    chk(nwe == 16, "R3 sixteen slot writes", nwe, 16);
    rd_exp(8'h14, "R8 pointer after overrun");
    seek(8'h43);
    rd_exp(8'h20, "R3 slot overwritten by byte 16");
    rd_exp(8'h21, "R3 slot overwritten by byte 17");

    // Pointer wrap, large size
    wr(8'hFF, 1, 8'hE1, nb, nwe);
    wr(8'h00, 1, 8'hE2, nb, nwe);
    seek(8'hFF);
    rd_exp(8'hE1, "R7 read at FFh");
    rd_exp(8'hE2, "R7 wrap FFh to 00h");

    // Pointer wrap, small size
    size_large = 1'b0;
    wr(8'h7F, 1, 8'hD1, nb, nwe);
    wr(8'h00, 1, 8'hD2, nb, nwe);
    seek(8'h7F);
    rd_exp(8'hD1, "R7 read at 7Fh");
    rd_exp(8'hD2, "R7 wrap 7Fh to 00h");
    seek(8'hFF);
    rd_exp(8'hD1, "R7 address masked to 7 bits");

    // Strobes during busy
    wr(8'h11, 1, 8'h5B, nb, nwe);
    pulse(K_ADDR, 8'h10);
    pulse(K_DATA, 8'h5A);
    pulse(K_STOP, 8'h00);
    pulse(K_RD, 8'h00);
    chk(rd_valid == 1'b0, "R5 read ignored while busy", rd_valid, 0);
    pulse(K_ADDR, 8'h7F);
    pulse(K_DATA, 8'h99);
    pulse(K_STOP, 8'h00);
    wait_idle(nb, nwe);
    rd_exp(8'h5B, "R5 pointer untouched by strobes while busy");
    size_large = 1'b1;

    // Low-voltage inhibit
    wr(8'h50, 1, 8'hF0, nb, nwe);
    lv = 1'b1;
    wr(8'h50, 1, 8'hF1, nb, nwe);
    chk(nb == WRC, "R12 busy window runs under inhibit", nb, WRC);
    chk(nwe == 0, "R12 no writes under inhibit", nwe, 0);
    lv = 1'b0;
    seek(8'h50);
    rd_exp(8'hF0, "R12 array unchanged");
    lv = 1'b1;
    pulse(K_FUSE, 8'h00);
    pulse(K_STOP, 8'h00);
    wait_idle(nb, nwe);
    lv = 1'b0;
    chk(nb == WRC, "R12 fuse window under inhibit", nb, WRC);
    wr(8'h10, 1, 8'h61, nb, nwe);
    chk(nwe == 1, "R12 fuse not set under inhibit", nwe, 1);

    // Fuse, large size
    pulse(K_FUSE, 8'h00);
    pulse(K_STOP, 8'h00);
    wait_idle(nb, nwe);
    chk(nb == WRC, "R10 fuse busy window", nb, WRC);
    wr(8'h10, 1, 8'h62, nb, nwe);
    chk(nwe == 0, "R11 lower half protected", nwe, 0);
    chk(nb == WRC, "R11 protected write keeps busy window", nb, WRC);
    seek(8'h10);
    rd_exp(8'h61, "R11 protected byte unchanged");
    wr(8'h90, 1, 8'h63, nb, nwe);
    chk(nwe == 1, "R11 upper half writable", nwe, 1);
    seek(8'h90);
    rd_exp(8'h63, "R11 upper half data");
    pulse(K_FUSE, 8'h00);
    pulse(K_STOP, 8'h00);
    chk(busy == 1'b0, "R10 second fuse command ignored", busy, 0);

    // Fuse, small size
    size_large = 1'b0;
    wr(8'h70, 1, 8'h64, nb, nwe);
    chk(nwe == 0, "R11 small size fully protected", nwe, 0);

    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule